// File: doc/BRIEF.md
# Pseudorandom Sub-block Length Generator

This block produces ten lengths that split a 128-bit plaintext into sub-blocks for parallel encryption. A 4-bit linear feedback shift register supplies the randomness. It is loaded from a seed while reset is held, and it advances once for every length that is drawn. The first nine lengths are mapped into the range 11..16. The tenth is whatever remains of the 128-bit total.

A start pulse begins the generation of one list. When a list is complete, the outputs update and a one-cycle done pulse marks it. The outputs then hold until the next list is ready.

If the remainder falls outside the allowed window, the nine drawn lengths are thrown away. The draw is repeated, continuing from the current register state, until the remainder is acceptable.

The encrypting side and the decrypting side each hold an identical instance. Both are given the same seed and the same sequence of start pulses, so they arrive at the same split.

Top module: `sublen_gen`

## Requirements
- R1: While reset (rst_n low) is held, and on the first cycle after it is released, done is 0 and every length field reads 0.
- R2: The generator register is loaded from the seed during reset. Each draw replaces the state s with {s[1]^s[0], s[3:1]}, so seed 1 visits 1, 8, 4, 2, 9, 12, 6, 11, 5, 10, 13, 14, 15, 7, 3 and then repeats.
- R3: A seed of 0 behaves exactly like a seed of 1, and the register never reaches 0.
- R4: Draw i (i = 0..8) places (s mod 6) + 11 in field i of lens, where s is the register state at the moment of that draw. Field i occupies bits 5*i+4 : 5*i.
- R5: Field 9 holds 128 minus the sum of fields 0..8. The ten fields sum to 128, and field 9 lies in RMIN..RMAX (4..16 by default).
- R6: If the remainder falls outside RMIN..RMAX, the nine draws are discarded and drawn again from the current register state, with no reload, until the remainder fits.
- R7: done is a one-cycle pulse. It rises 10*k cycles after the clock edge that samples start, where k is the number of attempts. The lens outputs change only in the cycle in which done is high.
- R8: A start pulse that arrives while a list is being generated is ignored, and it changes neither the result nor its timing.
- R9: Two instances given the same seed, reset and start sequence produce identical lists in the same cycles.
- R10: A further start pulse after a completed list continues from the register state that the previous list left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the seed is loaded while it is low |
| seed | input | 4 | Initial register state, where 0 is replaced by 1 |
| start | input | 1 | Request for a new list, honoured only when the block is idle |
| done | output | 1 | One-cycle pulse that marks a new list on lens |
| lens | output | 50 | Ten 5-bit lengths, field i at bits 5*i+4:5*i |

## Verification
The edge that samples start begins a list. Nine draw cycles and one check cycle follow, so a list that needs k attempts shows done, together with the new lens, on the 10*k-th edge after that sampling edge.

The bench drives start half a cycle before an edge and then samples once after every edge. It requires done to appear on exactly that edge, and it compares the list against a model of the register sequence.

The default window never rejects a draw with this register and mapping. The redraw path is therefore exercised by a second instance with a narrow remainder window, which must report done 20 edges after start for seed 1.

// File: rtl/sublen_gen.sv
module sublen_gen #(
  parameter int NLEN  = 10,
  parameter int LW    = 5,
  parameter int TOTAL = 128,
  parameter int LMIN  = 11,
  parameter int NSPAN = 6,
  parameter int RMIN  = 4,
  parameter int RMAX  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               seed,
  input  logic                     start,
  output logic                     done,
  output logic [NLEN-1:0][LW-1:0]  lens
);
  localparam int NDRAW = NLEN - 1;
  localparam int CW    = $clog2(NDRAW + 1);
  localparam int SW    = $clog2(NDRAW * (LMIN + NSPAN - 1) + 1);

  logic [3:0]               lfsr;
  logic                     busy;
  logic [CW-1:0]            phase;
  logic [SW-1:0]            acc;
  logic [NDRAW-1:0][LW-1:0] stage;
  logic [LW-1:0]            draw;
  logic signed [SW:0]       rem;
  logic                     fits;

  assign draw = LW'(32'(lfsr) % NSPAN + LMIN);
  assign rem  = (SW+1)'(TOTAL) - $signed({1'b0, acc});
  assign fits = (rem >= RMIN) && (rem <= RMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr  <= (seed == 4'd0) ? 4'd1 : seed;
      busy  <= 1'b0;
      phase <= '0;
      acc   <= '0;
      stage <= '0;
      lens  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= '0;
          acc   <= '0;
        end
      end else if (phase < CW'(NDRAW)) begin
        stage[phase] <= draw;
        acc          <= acc + SW'(draw);
        lfsr         <= {lfsr[1] ^ lfsr[0], lfsr[3:1]};
        phase        <= phase + 1'b1;
      end else begin
        if (fits) begin
          lens <= {rem[LW-1:0], stage};
          done <= 1'b1;
          busy <= 1'b0;
        end
        phase <= '0;
        acc   <= '0;
      end
    end
  end
endmodule

// File: rtl/sublen_gen_chk.sv
module sublen_gen_chk #(
  parameter int NLEN  = 10,
  parameter int LW    = 5,
  parameter int TOTAL = 128,
  parameter int LMIN  = 11,
  parameter int NSPAN = 6,
  parameter int RMIN  = 4,
  parameter int RMAX  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    done,
  input logic [NLEN-1:0][LW-1:0] lens,
  input logic [3:0]              lfsr,
  input logic                    busy
);
  function automatic int total_of(input logic [NLEN-1:0][LW-1:0] v);
    int s = 0;
    for (int i = 0; i < NLEN; i++) s += int'(v[i]);
    return s;
  endfunction

  function automatic bit draws_ok(input logic [NLEN-1:0][LW-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < NLEN - 1; i++)
      if (int'(v[i]) < LMIN || int'(v[i]) > LMIN + NSPAN - 1) ok = 1'b0;
    return ok;
  endfunction

  assert_sum_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> total_of(lens) == TOTAL);
  assert_tail_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(lens[NLEN-1]) >= RMIN && int'(lens[NLEN-1]) <= RMAX));
  assert_draw_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> draws_ok(lens));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lens) |-> done);
  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 4'd0);
endmodule

bind sublen_gen sublen_gen_chk #(
  .NLEN(NLEN), .LW(LW), .TOTAL(TOTAL), .LMIN(LMIN),
  .NSPAN(NSPAN), .RMIN(RMIN), .RMAX(RMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .lens(lens),
  .lfsr(lfsr), .busy(busy)
);

// File: tb/sublen_gen_test.sv
module sublen_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] seed = 4'd1;
  logic start = 1'b0, start_n = 1'b0;
  logic done, done_t, done_n;
  logic [9:0][4:0] lens, lens_t, lens_n;

  int total = 0, fails = 0, cycles = 0;
  logic [3:0] st_def, st_nar;

  always #2 clk = ~clk;

  sublen_gen uut (.clk(clk), .rst_n(rst_n), .seed(seed), .start(start),
                  .done(done), .lens(lens));
  sublen_gen uut_twin (.clk(clk), .rst_n(rst_n), .seed(seed), .start(start),
                       .done(done_t), .lens(lens_t));
  sublen_gen #(.RMIN(8), .RMAX(10)) uut_narrow (.clk(clk), .rst_n(rst_n),
    .seed(seed), .start(start_n), .done(done_n), .lens(lens_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nx(input logic [3:0] s);
    return {s[1] ^ s[0], s[3:1]};
  endfunction

  task automatic model(input int rmin, input int rmax, inout logic [3:0] st,
                       output logic [9:0][4:0] l, output int att);
    int sum, rem;
    att = 0;
    do begin
      att++;
      sum = 0;
      for (int i = 0; i < 9; i++) begin
        l[i] = 5'(int'(st) % 6 + 11);
        sum += int'(l[i]);
        st = nx(st);
      end
      rem = 128 - sum;
    end while (!(rem >= rmin && rem <= rmax));
    l[9] = 5'(rem);
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    seed = s;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    st_def = (s == 4'd0) ? 4'd1 : s;
    st_nar = st_def;
    @(posedge clk);
    #1;
    chk(done == 1'b0 && done_n == 1'b0, "R1", "done after reset", 64'(done), 0);
    chk(lens == '0 && lens_n == '0, "R1", "lens after reset", 64'(lens), 0);
  endtask

  task automatic run_list(input string req, input int mid_start,
                          output logic [9:0][4:0] got);
    logic [9:0][4:0] exp, prev;
    int att, n;
    prev = lens;
    model(4, 16, st_def, exp, att);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    n = 1;
    while (n < 400) begin
      if (mid_start > 0 && n == mid_start) start = 1'b1;
      else start = 1'b0;
      @(posedge clk);
      #1;
      n++;
      if (n == 5) chk(lens == prev, "R7", "lens held while busy", 64'(lens), 64'(prev));
      if (done) break;
    end
    start = 1'b0;
    got = lens;
    chk(n == 1 + 10 * att, mid_start > 0 ? "R8" : "R7", "done edge count",
        64'(n), 64'(1 + 10 * att));
    chk(lens == exp, req, "list", 64'(lens), 64'(exp));
    chk(done_t && lens_t == lens, "R9", "twin list", 64'(lens_t), 64'(lens));
    @(posedge clk);
    #1;
    chk(!done && lens == got, "R7", "done pulse ends, lens hold", 64'(done), 0);
  endtask

  initial begin
    logic [9:0][4:0] got, exp1, exp2, expn;
    int att, n;
    void'($urandom(32'd4242));
    exp1 = {5'd7, 5'd16, 5'd16, 5'd11, 5'd11, 5'd14, 5'd13, 5'd15, 5'd13, 5'd12};
    exp2 = {5'd7, 5'd13, 5'd12, 5'd15, 5'd16, 5'd16, 5'd11, 5'd11, 5'd14, 5'd13};

    do_reset(4'd1);
    run_list("R4", 0, got);
    chk(got == exp1, "R2", "seed 1 directed list", 64'(got), 64'(exp1));
    run_list("R10", 0, got);

    do_reset(4'd2);
    run_list("R4", 0, got);
    chk(got == exp2, "R2", "seed 2 directed list", 64'(got), 64'(exp2));

    do_reset(4'd0);
    run_list("R3", 0, got);
    chk(got == exp1, "R3", "seed 0 acts as seed 1", 64'(got), 64'(exp1));

    do_reset(4'd11);
    run_list("R5", 0, got);
    chk(got[9] == 5'd4, "R5", "remainder at lower bound", 64'(got[9]), 4);

    do_reset(4'd6);
    run_list("R8", 4, got);

    do_reset(4'd1);
    model(8, 10, st_nar, expn, att);
    chk(att == 2, "R6", "model attempts for seed 1", 64'(att), 2);
    @(negedge clk);
    start_n = 1'b1;
    @(posedge clk);
    #1 start_n = 1'b0;
    n = 1;
    while (n < 400) begin
      @(posedge clk);
      #1;
      n++;
      if (done_n) break;
    end
    chk(n == 1 + 10 * att, "R6", "redraw done edge count", 64'(n), 64'(1 + 10 * att));
    chk(lens_n == expn, "R6", "redrawn list", 64'(lens_n), 64'(expn));

    for (int it = 0; it < 12; it++) begin
      do_reset(4'($urandom % 16));
      for (int k = 0; k < 1 + int'($urandom % 3); k++)
        run_list("R5", ($urandom % 2 == 0) ? 0 : 2 + int'($urandom % 7), got);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      fails++;
      $display("FAIL R7 watchdog expired: actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule